// File: doc/BRIEF.md
# Flash Write-Buffer Load Controller

This block runs the buffered-program load phase of a NOR-style flash command interface. An upstream command decoder pulses `cmd_start` when it recognises the write-to-buffer command and hands over the sector address that command was written to. From then on the controller watches every bus write itself. The next write must target the same sector and carries a word count, encoded as the number of words to load minus one. The count is followed by that many address/data writes into a small page buffer, and the sequence ends with a confirm write.

Every loaded address must sit in the same buffer page as the first loaded address. The buffer stores each word at the location given by the low address bits, and keeps a valid bit for each location. A correct confirm is the data byte 29h written to the latched sector. It produces a one-cycle program request that presents the first address, the count and the valid mask next to the buffer contents, and the controller then goes back to idle. Any violation discards the buffer and raises a sticky abort flag. Only a three-write recovery sequence clears that flag.

Top module: `wbl_loader`

## Requirements
- R1: After reset, `abort_flag` and `prog_req` are 0 and `buf_valid` is all zeros.
- R2: The first write after `cmd_start` that targets the latched sector (address bits [ADDR_W-1:SECT_LSB]) is taken as the word count minus one. If its value is larger than DEPTH-1, the controller aborts.
- R3: Each data write stores `wr_data` at buffer location `wr_addr[PAGE_W-1:0]` and sets that location's valid bit. The address of the first data write becomes `prog_base`.
- R4: A data write after the first one whose page (`wr_addr[ADDR_W-1:PAGE_W]`) differs from the first write's page aborts the load. The valid mask reads all zeros while the controller is aborted.
- R5: A location written twice keeps the last data. Every data write counts toward the word total, including repeats.
- R6: After count+1 data writes, a write whose low data byte is 29h and whose address is in the latched sector raises `prog_req` for exactly one cycle. During that cycle `prog_base`, `prog_count` (the count as written) and `buf_valid` are valid, and the controller returns to idle.
- R7: A confirm write with any other data byte, or aimed at another sector, aborts the load.
- R8: While aborted, `cmd_start` and all other writes are ignored. The flag clears only after the writes AAh at 555h, then 55h at 2AAh, then F0h at 555h (low 12 address bits, low 8 data bits compared). A wrong write restarts the recovery match; a wrong write that is itself AAh at 555h counts as its first step.
- R9: A count write aimed at a sector other than the latched one aborts the load.
- R10: While idle, bus writes have no effect: no request, no abort, and the buffer is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Decoder pulse: write-to-buffer command seen |
| cmd_sector | input | ADDR_W-SECT_LSB | Sector of the command write |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Bus write word address |
| wr_data | input | DATA_W | Bus write data |
| prog_req | output | 1 | One-cycle program request |
| prog_base | output | ADDR_W | Address of the first loaded word |
| prog_count | output | PAGE_W | Word count minus one |
| buf_valid | output | DEPTH | Per-location valid mask |
| buf_data | output | DEPTH*DATA_W | Buffer contents, location i at bits [i*DATA_W +: DATA_W] |
| abort_flag | output | 1 | Sticky abort indication |

## Verification
The bench targets the edges of the count:
- A single word (count 0) and a full page (count DEPTH-1). A design with an off-by-one word counter either asks for the confirm one write early or takes the confirm as data.
- Counts just above DEPTH-1 must abort rather than wrap.

Repeated locations check that the last data wins while the total still advances. Out-of-page writes, a wrong confirm byte or sector, and a mis-sectored count must each abort and empty the mask. Inside the abort state the bench sends start pulses, a broken recovery that restarts on AAh at 555h, and stray writes, so a controller that leaks out of abort early, or that accepts a new command there, is exposed.

// File: rtl/wbl_pkg.sv
package wbl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_COUNT   = 3'd1,
    ST_LOAD    = 3'd2,
    ST_CONFIRM = 3'd3,
    ST_ABORT   = 3'd4
  } wbl_state_e;

  localparam logic [7:0]  CONFIRM_BYTE = 8'h29;
  localparam logic [7:0]  RCV_BYTE0    = 8'hAA;
  localparam logic [7:0]  RCV_BYTE1    = 8'h55;
  localparam logic [7:0]  RCV_BYTE2    = 8'hF0;
  localparam logic [11:0] RCV_ADDR_A   = 12'h555;
  localparam logic [11:0] RCV_ADDR_B   = 12'h2AA;

endpackage

// File: rtl/wbl_page_buf.sv
module wbl_page_buf #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DEPTH-1:0]        valid,
  output logic [DEPTH*DATA_W-1:0] data_flat
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              hit;
    logic              vld_q, vld_d;
    logic [DATA_W-1:0] dat_q;

    assign hit = we && (idx == IDX_W'(g));

    always_comb begin
      vld_d = vld_q;
      if (clr)      vld_d = 1'b0;
      else if (hit) vld_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   dat_q <= '0;
      else if (hit) dat_q <= wdata;
    end

    assign valid[g]                       = vld_q;
    assign data_flat[g*DATA_W +: DATA_W]  = dat_q;
  end

endmodule

// File: rtl/wbl_recover.sv
module wbl_recover #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              done
);
  import wbl_pkg::*;

  logic [1:0] step_q, step_d;
  logic       is_s0, is_s1, is_s2;

  assign is_s0 = (wr_addr[11:0] == RCV_ADDR_A) && (wr_data[7:0] == RCV_BYTE0);
  assign is_s1 = (wr_addr[11:0] == RCV_ADDR_B) && (wr_data[7:0] == RCV_BYTE1);
  assign is_s2 = (wr_addr[11:0] == RCV_ADDR_A) && (wr_data[7:0] == RCV_BYTE2);

  assign done = arm && wr_en && (step_q == 2'd2) && is_s2;

  always_comb begin
    step_d = step_q;
    if (!arm) begin
      step_d = 2'd0;
    end else if (wr_en) begin
      if      (step_q == 2'd0 && is_s0) step_d = 2'd1;
      else if (step_q == 2'd1 && is_s1) step_d = 2'd2;
      else if (step_q == 2'd2 && is_s2) step_d = 2'd0;
      else if (is_s0)                   step_d = 2'd1;
      else                              step_d = 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= 2'd0;
    else        step_q <= step_d;
  end

endmodule

// File: rtl/wbl_loader.sv
module wbl_loader #(
  parameter int ADDR_W   = 22,
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 16,
  parameter int SECT_LSB = 15,
  localparam int PAGE_W  = $clog2(DEPTH),
  localparam int SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_start,
  input  logic [SECT_W-1:0]       cmd_sector,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic                    prog_req,
  output logic [ADDR_W-1:0]       prog_base,
  output logic [PAGE_W-1:0]       prog_count,
  output logic [DEPTH-1:0]        buf_valid,
  output logic [DEPTH*DATA_W-1:0] buf_data,
  output logic                    abort_flag
);
  import wbl_pkg::*;

  localparam logic [DATA_W-1:0] MAX_CNT = DATA_W'(DEPTH - 1);

  wbl_state_e        state_q, state_d;
  logic [SECT_W-1:0] sect_q, sect_d;
  logic [PAGE_W-1:0] left_q, left_d;
  logic [PAGE_W-1:0] cnt_q, cnt_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              first_q, first_d;
  logic              req_q, req_d;

  logic              sect_hit, page_hit, rcv_done;
  logic              buf_clr, buf_we;

  assign sect_hit = (wr_addr[ADDR_W-1:SECT_LSB] == sect_q);
  assign page_hit = (wr_addr[ADDR_W-1:PAGE_W] == base_q[ADDR_W-1:PAGE_W]);

  always_comb begin
    state_d = state_q;
    sect_d  = sect_q;
    left_d  = left_q;
    cnt_d   = cnt_q;
    base_d  = base_q;
    first_d = first_q;
    req_d   = 1'b0;
    buf_we  = 1'b0;
    buf_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_start) begin
          state_d = ST_COUNT;
          sect_d  = cmd_sector;
          buf_clr = 1'b1;
        end
      end
      ST_COUNT: begin
        if (wr_en) begin
          if (!sect_hit || (wr_data > MAX_CNT)) begin
            state_d = ST_ABORT;
          end else begin
            cnt_d   = wr_data[PAGE_W-1:0];
            left_d  = wr_data[PAGE_W-1:0];
            first_d = 1'b1;
            state_d = ST_LOAD;
          end
        end
      end
      ST_LOAD: begin
        if (wr_en) begin
          if (!first_q && !page_hit) begin
            state_d = ST_ABORT;
          end else begin
            buf_we  = 1'b1;
            first_d = 1'b0;
            if (first_q) base_d = wr_addr;
            if (left_q == '0) state_d = ST_CONFIRM;
            else              left_d  = left_q - 1'b1;
          end
        end
      end
      ST_CONFIRM: begin
        if (wr_en) begin
          if (sect_hit && (wr_data[7:0] == CONFIRM_BYTE)) begin
            req_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_ABORT;
          end
        end
      end
      ST_ABORT: begin
        if (rcv_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (state_d == ST_ABORT && state_q != ST_ABORT) buf_clr = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sect_q  <= '0;
      left_q  <= '0;
      cnt_q   <= '0;
      base_q  <= '0;
      first_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sect_q  <= sect_d;
      left_q  <= left_d;
      cnt_q   <= cnt_d;
      base_q  <= base_d;
      first_q <= first_d;
      req_q   <= req_d;
    end
  end

  wbl_page_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W)) buf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (buf_clr),
    .we        (buf_we),
    .idx       (wr_addr[PAGE_W-1:0]),
    .wdata     (wr_data),
    .valid     (buf_valid),
    .data_flat (buf_data)
  );

  wbl_recover #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rcv_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (state_q == ST_ABORT),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .done    (rcv_done)
  );

  assign prog_req   = req_q;
  assign prog_base  = base_q;
  assign prog_count = cnt_q;
  assign abort_flag = (state_q == ST_ABORT);

endmodule

// File: rtl/wbl_checker.sv
module wbl_checker #(
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic             wr_en,
  input logic             prog_req,
  input logic             abort_flag,
  input logic [DEPTH-1:0] buf_valid
);

  assert_req_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);

  assert_req_has_words_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> (buf_valid != '0));

  assert_no_req_aborted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_flag |-> !prog_req);

  assert_abort_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_flag && !wr_en) |=> abort_flag);

  assert_mask_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_flag |-> (buf_valid == '0));

  assert_req_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !abort_flag) |=> !prog_req);

endmodule

bind wbl_loader wbl_checker #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_start  (cmd_start),
  .wr_en      (wr_en),
  .prog_req   (prog_req),
  .abort_flag (abort_flag),
  .buf_valid  (buf_valid)
);

// File: tb/wbl_loader_tb.sv
module wbl_loader_tb_top;
  localparam int AW = 22, DW = 16, DEPTH = 16, SL = 15, PW = 4, SW = AW - SL;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_start = 1'b0;
  logic [SW-1:0]     cmd_sector = '0;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     wr_addr = '0;
  logic [DW-1:0]     wr_data = '0;
  logic              prog_req;
  logic [AW-1:0]     prog_base;
  logic [PW-1:0]     prog_count;
  logic [DEPTH-1:0]  buf_valid;
  logic [DEPTH*DW-1:0] buf_data;
  logic              abort_flag;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0]    m_data [DEPTH];
  logic [DEPTH-1:0] m_mask;

  always #10 clk = ~clk;

  wbl_loader dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_sector(cmd_sector),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_req(prog_req), .prog_base(prog_base), .prog_count(prog_count),
    .buf_valid(buf_valid), .buf_data(buf_data), .abort_flag(abort_flag)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] sect_addr(input logic [SW-1:0] s);
    return {s, 15'($urandom)};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic start(input logic [SW-1:0] s);
    @(negedge clk); cmd_start = 1'b1; cmd_sector = s;
    @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic expect_abort(input string tag);
    chk(abort_flag === 1'b1, tag, 64'(abort_flag), 64'd1);
    chk(buf_valid === '0, tag, 64'(buf_valid), 64'd0);
  endtask

  task automatic recover(input bit broken);
    if (broken) begin
      start(7'h11);
      wr(22'h000555, 16'h00AA);
      wr(22'h0002AA, 16'h0055);
      wr(22'h0002AA, 16'h00F0);          // wrong address for step three
      chk(abort_flag === 1'b1, "R8 broken recovery", 64'(abort_flag), 64'd1);
      wr(22'h000555, 16'h00AA);
      wr(22'h000555, 16'h00AA);          // restarts at step one
      wr(22'h0002AA, 16'h0055);
      chk(abort_flag === 1'b1, "R8 mid recovery", 64'(abort_flag), 64'd1);
      wr(22'h000555, 16'h00F0);
    end else begin
      wr(22'h3FF555, 16'hFFAA);
      wr(22'h2AA2AA, 16'h1255);
      wr(22'h000555, 16'h00F0);
    end
    chk(abort_flag === 1'b0, "R8 recovered", 64'(abort_flag), 64'd0);
  endtask

  // mode: 0 good, 1 big count, 2 off page, 3 bad confirm byte, 4 bad confirm sector, 5 count wrong sector
  task automatic run_load(input int mode, input int cnt, input bit dup);
    logic [SW-1:0]      s;
    logic [AW-PW-1:0]   pg;
    logic [AW-1:0]      a, base;
    logic [DW-1:0]      d;
    int                 bad_at;
    s = SW'($urandom); pg = (AW-PW)'($urandom);
    start(s);
    if (mode == 5) begin
      wr(sect_addr(s ^ 7'h01), 16'(cnt));
      expect_abort("R9 count sector"); recover($urandom_range(0, 1) == 1); return;
    end
    if (mode == 1) begin
      wr(sect_addr(s), 16'(DEPTH + $urandom_range(0, 300)));
      expect_abort("R2 count too big"); recover($urandom_range(0, 1) == 1); return;
    end
    wr(sect_addr(s), 16'(cnt));
    m_mask = '0;
    bad_at = (cnt > 0) ? $urandom_range(1, cnt) : -1;
    base = '0;
    for (int i = 0; i <= cnt; i++) begin
      a = {pg, PW'($urandom)};
      if (dup && i > 0) a = base;
      if (mode == 2 && i == bad_at) begin
        wr({pg ^ 18'h00040, a[PW-1:0]}, 16'hDEAD);
        expect_abort("R4 off page"); recover(1'b0); return;
      end
      d = DW'($urandom);
      if (i == 0) base = a;
      m_data[a[PW-1:0]] = d;
      m_mask[a[PW-1:0]] = 1'b1;
      wr(a, d);
      if (i < cnt)
        chk(prog_req === 1'b0 && abort_flag === 1'b0, "R5 no early request", 64'(prog_req), 64'd0);
    end
    if (mode == 3) begin
      wr(sect_addr(s), 16'h0028);
      expect_abort("R7 confirm byte"); recover(1'b1); return;
    end
    if (mode == 4 || (mode == 2 && cnt == 0)) begin
      wr(sect_addr(s ^ 7'h40), 16'h0029);
      expect_abort("R7 confirm sector"); recover(1'b0); return;
    end
    wr(sect_addr(s), 16'hFF29);
    chk(prog_req === 1'b1, "R6 request", 64'(prog_req), 64'd1);
    chk(prog_base === base, "R3 base", 64'(prog_base), 64'(base));
    chk(prog_count === PW'(cnt), "R2 count", 64'(prog_count), 64'(cnt));
    chk(buf_valid === m_mask, "R3 mask", 64'(buf_valid), 64'(m_mask));
    for (int k = 0; k < DEPTH; k++)
      if (m_mask[k])
        chk(buf_data[k*DW +: DW] === m_data[k], dup ? "R5 last data" : "R3 data",
            64'(buf_data[k*DW +: DW]), 64'(m_data[k]));
    @(negedge clk);
    chk(prog_req === 1'b0, "R6 single pulse", 64'(prog_req), 64'd0);
    wr(sect_addr(s), 16'h0029);          // idle again: no effect
    chk(prog_req === 1'b0 && abort_flag === 1'b0, "R6 back to idle", 64'(prog_req), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk);
    chk(abort_flag === 1'b0, "R1 abort", 64'(abort_flag), 64'd0);
    chk(prog_req === 1'b0, "R1 req", 64'(prog_req), 64'd0);
    chk(buf_valid === '0, "R1 mask", 64'(buf_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: idle writes ignored
    wr(22'h000000, 16'h0003);
    wr(22'h000010, 16'h1234);
    wr(22'h000000, 16'h0029);
    chk(prog_req === 1'b0 && abort_flag === 1'b0, "R10 idle write", 64'(prog_req), 64'd0);
    chk(buf_valid === '0, "R10 idle mask", 64'(buf_valid), 64'd0);
    // directed corners
    run_load(0, 0, 1'b0);
    run_load(0, DEPTH - 1, 1'b0);
    run_load(0, 5, 1'b1);
    run_load(1, 0, 1'b0);
    run_load(2, 3, 1'b0);
    run_load(3, 2, 1'b0);
    run_load(4, 1, 1'b0);
    run_load(5, 2, 1'b0);
    // random mix
    for (int n = 0; n < 80; n++) begin
      int r;
      r = $urandom_range(0, 9);
      run_load((r > 5) ? 0 : r, $urandom_range(0, DEPTH - 1), $urandom_range(0, 3) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule